// File: doc/BRIEF.md
# Paged Receive Ring Writer

This block stores received frames in a circular buffer held in a local byte-wide memory. The buffer is split into 256-byte pages. Two page numbers, a first page and a limit page, mark the ring. The limit page itself is never written. A receive MAC feeds the block a byte stream with start-of-frame, end-of-frame and error flags. The block writes the frame data into the ring starting at offset 4 of the current page. Once the frame is complete, it fills the first four bytes of that page with a header. If the frame is kept, the current page then moves on to the page that follows the frame.

The host sets the read boundary, which is the last page it has not yet consumed. The host must not set the boundary equal to the current page. A byte that would fall into the boundary page is not written. Instead, the block drops the frame, raises an overwrite warning and counts the frame as missed. Acceptance controls can reject runts, errored frames and broadcast frames. A monitor mode checks frames without storing them. The block reports the status of the last frame and raises single-cycle pulses for a stored frame, for a receive error and for an overwrite warning.

Top module: `rx_ring_writer`

## Requirements
- R1: While `rstN` is low at a clock edge, `currPage` loads `pageStart`. At the same edge, `missedCount` and `rxStatus` clear to 0, and `memWe` and all three pulses go low.
- R2: Data bytes of a frame are written in arrival order, one write per byte. The write address is `{page, offset}`, with the page in the upper 8 bits. The first byte goes to offset 4 of `currPage`, and the offset then increments by one for each byte. Bytes with `rxValid` low are skipped.
- R3: In the four cycles after the last byte of a kept frame, the block writes the header to offsets 0, 1, 2 and 3 of the frame's first page. The header bytes are, in that order: the status byte, the next page, the length low byte and the length high byte. The length counts every byte of the frame, FCS included. Frames must be separated by at least four idle cycles.
- R4: For a kept frame, the next page is the page after the one that holds the last byte. `currPage` takes that value in the same cycle in which `pktRcvd` pulses, which is the cycle of the last header write.
- R5: After offset 255 of page `pageStop-1`, writing continues at offset 0 of `pageStart`. The next-page value wraps in the same way, and `currPage` always stays inside the ring.
- R6: A frame shorter than 64 bytes is a runt. A runt is discarded unless `cfgAcceptRunt` is 1. A discarded frame gets no header write, no `pktRcvd` pulse, and leaves `currPage` unchanged.
- R7: A frame whose end byte carries `rxCrcErr` or `rxAlignErr` is discarded unless `cfgSaveErr` is 1. Every such frame, stored or not and in monitor mode too, raises `rxErrPulse` one cycle after its end byte.
- R8: A frame whose first six bytes are all 0xFF is a broadcast. A broadcast is discarded unless `cfgAcceptBcast` is 1.
- R9: With `cfgMonitor` at 1, a frame causes no memory write and no `pktRcvd` pulse. The frame still updates `rxStatus` and increments `missedCount`.
- R10: If a data byte would be written to the page equal to `boundary`, that byte and the rest of the frame are not written. One cycle later `ovwWarn` and `rxErrPulse` pulse. `missedCount` increments, `rxStatus` becomes 0x10 and `currPage` is unchanged.
- R11: After each frame that completes without overwrite, `rxStatus` is set as follows:
  - bit 0 is 1 when neither error flag is set;
  - bit 1 is the CRC error flag;
  - bit 2 is the alignment error flag;
  - bit 5 is bit 0 of the first frame byte;
  - bit 6 is the monitor setting;
  - bits 3, 4 and 7 are 0.
- R12: `missedCount` saturates at 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| rxValid | input | 1 | A stream byte is present |
| rxData | input | 8 | Stream byte |
| rxSof | input | 1 | Byte is the first of a frame |
| rxEof | input | 1 | Byte is the last of a frame |
| rxCrcErr | input | 1 | CRC error flag, sampled with the end byte |
| rxAlignErr | input | 1 | Alignment error flag, sampled with the end byte |
| pageStart | input | 8 | First page of the ring |
| pageStop | input | 8 | Limit page, first page outside the ring |
| boundary | input | 8 | Host read boundary page |
| cfgSaveErr | input | 1 | Keep frames with CRC or alignment errors |
| cfgAcceptRunt | input | 1 | Keep frames shorter than 64 bytes |
| cfgAcceptBcast | input | 1 | Keep broadcast frames |
| cfgMonitor | input | 1 | Check frames but store nothing |
| memWe | output | 1 | Memory write enable |
| memAddr | output | 16 | Memory byte address {page, offset} |
| memData | output | 8 | Memory write data |
| currPage | output | 8 | Page where the next frame begins |
| rxStatus | output | 8 | Status of the last frame |
| pktRcvd | output | 1 | Pulse: a frame was stored |
| rxErrPulse | output | 1 | Pulse: errored or missed frame |
| ovwWarn | output | 1 | Pulse: overwrite of the boundary page was blocked |
| missedCount | output | 8 | Count of missed frames |

## Verification
Several frame patterns each separate one decision from the others:
- Lengths of 63 and 64 bytes isolate the runt threshold.
- Broadcast and non-broadcast frames of the same length isolate the address check.
- CRC-errored and alignment-errored frames, sent with the save control both off and on, show that the error check is independent of the other acceptance rules.
- Frames of about 500 bytes sent in a row cross the limit page, so the wrapped data addresses and the wrapped next-page field become visible.
- A 700-byte frame sent against a boundary two pages ahead shows exactly where storing stops.

Random lengths, flags and controls, with a bench that frees pages after each frame, then mix these cases together. Over 260 monitor frames, the missed counter is driven into saturation.

// File: rtl/rxring_pkg.sv
package rxring_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RECV,
    ST_MON,
    ST_DROP,
    ST_HDR
  } ringState_t;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic       frameStart;
    logic       byteWr;
    logic       frameEnd;
    logic       ovf;
    logic       missInc;
    logic       hdrWr;
    logic [1:0] hdrIdx;
    logic       commit;
  } ringStrobe_t;

  localparam int HDR_BYTES   = 4;
  localparam int BCAST_BYTES = 6;
  localparam int LEN_W       = 16;
  localparam logic [7:0] STATUS_MISSED = 8'h10;

endpackage

// File: rtl/rxring_ctl.sv
module rxring_ctl
  import rxring_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        rxValid,
  input  logic        rxSof,
  input  logic        rxEof,
  input  logic        cfgSaveErr,
  input  logic        cfgAcceptRunt,
  input  logic        cfgAcceptBcast,
  input  logic        cfgMonitor,
  input  logic        hitBoundary,
  input  logic        isRunt,
  input  logic        isBcast,
  input  logic        hasErr,
  output logic        inIdle,
  output ringStrobe_t strobe
);

  ringState_t state, stateNext;
  logic [1:0] hdrIdx;
  logic       keepNow;
  logic       startNormal;
  logic       dataByte;

  assign keepNow = (!isRunt || cfgAcceptRunt) && (!hasErr || cfgSaveErr) &&
                   (!isBcast || cfgAcceptBcast);
  assign inIdle      = (state == ST_IDLE);
  assign startNormal = inIdle && rxValid && rxSof && !cfgMonitor;
  assign dataByte    = startNormal || ((state == ST_RECV) && rxValid);

  always_comb begin
    strobe        = '0;
    strobe.hdrIdx = hdrIdx;
    stateNext     = state;
    if (inIdle && rxValid && rxSof) strobe.frameStart = 1'b1;
    if (dataByte) begin
      if (hitBoundary) begin
        strobe.ovf = 1'b1;
        stateNext  = rxEof ? ST_IDLE : ST_DROP;
      end else begin
        strobe.byteWr = 1'b1;
        if (rxEof) begin
          strobe.frameEnd = 1'b1;
          stateNext       = keepNow ? ST_HDR : ST_IDLE;
        end else begin
          stateNext = ST_RECV;
        end
      end
    end else begin
      case (state)
        ST_IDLE: if (rxValid && rxSof) begin
          if (rxEof) begin
            strobe.frameEnd = 1'b1;
            strobe.missInc  = 1'b1;
          end else begin
            stateNext = ST_MON;
          end
        end
        ST_MON: if (rxValid && rxEof) begin
          strobe.frameEnd = 1'b1;
          strobe.missInc  = 1'b1;
          stateNext       = ST_IDLE;
        end
        ST_DROP: if (rxValid && rxEof) stateNext = ST_IDLE;
        ST_HDR: begin
          strobe.hdrWr = 1'b1;
          if (hdrIdx == 2'd3) begin
            strobe.commit = 1'b1;
            stateNext     = ST_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      hdrIdx <= '0;
    end else begin
      state  <= stateNext;
      hdrIdx <= (state == ST_HDR) ? hdrIdx + 2'd1 : 2'd0;
    end
  end

  // R3: the header is written as an unbroken burst of four cycles
  p_hdr_burst_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HDR && hdrIdx != 2'd3) |=> (state == ST_HDR));

endmodule

// File: rtl/rxring_dp.sv
module rxring_dp
  import rxring_pkg::*;
#(
  parameter int PAGE_W    = 8,
  parameter int OFF_W     = 8,
  parameter int CNT_W     = 8,
  parameter int MIN_FRAME = 64
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [7:0]               rxData,
  input  logic                     rxCrcErr,
  input  logic                     rxAlignErr,
  input  logic [PAGE_W-1:0]        pageStart,
  input  logic [PAGE_W-1:0]        pageStop,
  input  logic [PAGE_W-1:0]        boundary,
  input  logic                     cfgMonitor,
  input  ringStrobe_t              strobe,
  input  logic                     inIdle,
  output logic                     hitBoundary,
  output logic                     isRunt,
  output logic                     isBcast,
  output logic                     hasErr,
  output logic                     memWe,
  output logic [PAGE_W+OFF_W-1:0]  memAddr,
  output logic [7:0]               memData,
  output logic [PAGE_W-1:0]        currPage,
  output logic [7:0]               rxStatus,
  output logic                     pktRcvd,
  output logic                     rxErrPulse,
  output logic                     ovwWarn,
  output logic [CNT_W-1:0]         missedCount
);

  localparam int ADDR_W = PAGE_W + OFF_W;

  logic [PAGE_W-1:0] wrPage, pageNow, pageAfter, nextPage;
  logic [OFF_W-1:0]  wrOff, offNow;
  logic [LEN_W-1:0]  frameLen, lenNow, lenReg;
  logic              bcastRun, prefixSoFar, prefixNow, groupBit, groupNow;
  logic [7:0]        hdrByte;

  function automatic logic [PAGE_W-1:0] stepPage(input logic [PAGE_W-1:0] p,
                                                 input logic [PAGE_W-1:0] first,
                                                 input logic [PAGE_W-1:0] limit);
    logic [PAGE_W-1:0] inc;
    inc = p + 1'b1;
    return (inc == limit) ? first : inc;
  endfunction

  // position of the byte presented this cycle
  assign pageNow   = inIdle ? currPage : wrPage;
  assign offNow    = inIdle ? OFF_W'(HDR_BYTES) : wrOff;
  assign pageAfter = stepPage(pageNow, pageStart, pageStop);
  assign lenNow    = inIdle ? LEN_W'(1) : frameLen + LEN_W'(1);

  // classification of the frame up to and including this byte
  assign prefixSoFar = inIdle ? 1'b1 : bcastRun;
  assign prefixNow   = prefixSoFar && ((lenNow > LEN_W'(BCAST_BYTES)) || (rxData == 8'hFF));
  assign isBcast     = prefixNow && (lenNow >= LEN_W'(BCAST_BYTES));
  assign groupNow    = inIdle ? rxData[0] : groupBit;
  assign isRunt      = lenNow < LEN_W'(MIN_FRAME);
  assign hasErr      = rxCrcErr | rxAlignErr;
  assign hitBoundary = (pageNow == boundary);

  always_comb begin
    case (strobe.hdrIdx)
      2'd0:    hdrByte = rxStatus;
      2'd1:    hdrByte = 8'(nextPage);
      2'd2:    hdrByte = lenReg[7:0];
      default: hdrByte = lenReg[15:8];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      currPage    <= pageStart;
      wrPage      <= pageStart;
      wrOff       <= '0;
      frameLen    <= '0;
      lenReg      <= '0;
      nextPage    <= pageStart;
      bcastRun    <= 1'b0;
      groupBit    <= 1'b0;
      rxStatus    <= '0;
      memWe       <= 1'b0;
      memAddr     <= '0;
      memData     <= '0;
      pktRcvd     <= 1'b0;
      rxErrPulse  <= 1'b0;
      ovwWarn     <= 1'b0;
      missedCount <= '0;
    end else begin
      if (strobe.frameStart || strobe.byteWr) begin
        frameLen <= lenNow;
        bcastRun <= prefixNow;
        groupBit <= groupNow;
      end
      if (strobe.byteWr) begin
        wrOff  <= offNow + 1'b1;
        wrPage <= (&offNow) ? pageAfter : pageNow;
      end
      if (strobe.frameEnd) begin
        lenReg   <= lenNow;
        nextPage <= pageAfter;
        rxStatus <= {1'b0, cfgMonitor, groupNow, 1'b0, 1'b0, rxAlignErr, rxCrcErr, !hasErr};
      end else if (strobe.ovf) begin
        rxStatus <= STATUS_MISSED;
      end
      memWe <= strobe.byteWr | strobe.hdrWr;
      if (strobe.byteWr) begin
        memAddr <= {pageNow, offNow};
        memData <= rxData;
      end else if (strobe.hdrWr) begin
        memAddr <= {currPage, OFF_W'(strobe.hdrIdx)};
        memData <= hdrByte;
      end
      if (strobe.commit) currPage <= nextPage;
      if ((strobe.ovf || strobe.missInc) && !(&missedCount))
        missedCount <= missedCount + 1'b1;
      pktRcvd    <= strobe.commit;
      rxErrPulse <= strobe.ovf | (strobe.frameEnd & hasErr);
      ovwWarn    <= strobe.ovf;
    end
  end

  // R10: no write lands in the page the host still owns
  p_no_boundary_write_r10: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && $stable(boundary)) |-> (memAddr[ADDR_W-1:OFF_W] != boundary));

  // R10: every blocked overwrite is counted as missed
  p_ovw_counts_r10: assert property (@(posedge clk) disable iff (!rstN)
    ovwWarn |-> ((missedCount != $past(missedCount)) || (&missedCount)));

  // R5: the current page stays inside the ring
  p_curr_in_ring_r5: assert property (@(posedge clk) disable iff (!rstN)
    (pageStart < pageStop) |-> (currPage >= pageStart && currPage < pageStop));

  // R4: the stored pulse coincides with the last header byte write
  p_commit_hdr_r4: assert property (@(posedge clk) disable iff (!rstN)
    pktRcvd |-> (memWe && memAddr[OFF_W-1:0] == OFF_W'(3)));

endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
  import rxring_pkg::*;
#(
  parameter int PAGE_W    = 8,
  parameter int OFF_W     = 8,
  parameter int CNT_W     = 8,
  parameter int MIN_FRAME = 64
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    rxValid,
  input  logic [7:0]              rxData,
  input  logic                    rxSof,
  input  logic                    rxEof,
  input  logic                    rxCrcErr,
  input  logic                    rxAlignErr,
  input  logic [PAGE_W-1:0]       pageStart,
  input  logic [PAGE_W-1:0]       pageStop,
  input  logic [PAGE_W-1:0]       boundary,
  input  logic                    cfgSaveErr,
  input  logic                    cfgAcceptRunt,
  input  logic                    cfgAcceptBcast,
  input  logic                    cfgMonitor,
  output logic                    memWe,
  output logic [PAGE_W+OFF_W-1:0] memAddr,
  output logic [7:0]              memData,
  output logic [PAGE_W-1:0]       currPage,
  output logic [7:0]              rxStatus,
  output logic                    pktRcvd,
  output logic                    rxErrPulse,
  output logic                    ovwWarn,
  output logic [CNT_W-1:0]        missedCount
);

  ringStrobe_t strobe;
  logic        inIdle, hitBoundary, isRunt, isBcast, hasErr;

  rxring_ctl u_ctl (
    .clk           (clk),
    .rstN          (rstN),
    .rxValid       (rxValid),
    .rxSof         (rxSof),
    .rxEof         (rxEof),
    .cfgSaveErr    (cfgSaveErr),
    .cfgAcceptRunt (cfgAcceptRunt),
    .cfgAcceptBcast(cfgAcceptBcast),
    .cfgMonitor    (cfgMonitor),
    .hitBoundary   (hitBoundary),
    .isRunt        (isRunt),
    .isBcast       (isBcast),
    .hasErr        (hasErr),
    .inIdle        (inIdle),
    .strobe        (strobe)
  );

  rxring_dp #(
    .PAGE_W   (PAGE_W),
    .OFF_W    (OFF_W),
    .CNT_W    (CNT_W),
    .MIN_FRAME(MIN_FRAME)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .rxData     (rxData),
    .rxCrcErr   (rxCrcErr),
    .rxAlignErr (rxAlignErr),
    .pageStart  (pageStart),
    .pageStop   (pageStop),
    .boundary   (boundary),
    .cfgMonitor (cfgMonitor),
    .strobe     (strobe),
    .inIdle     (inIdle),
    .hitBoundary(hitBoundary),
    .isRunt     (isRunt),
    .isBcast    (isBcast),
    .hasErr     (hasErr),
    .memWe      (memWe),
    .memAddr    (memAddr),
    .memData    (memData),
    .currPage   (currPage),
    .rxStatus   (rxStatus),
    .pktRcvd    (pktRcvd),
    .rxErrPulse (rxErrPulse),
    .ovwWarn    (ovwWarn),
    .missedCount(missedCount)
  );

endmodule

// File: tb/rx_ring_writer_bench.sv
module rx_ring_writer_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rxValid = 1'b0;
  logic [7:0]  rxData = '0;
  logic        rxSof = 1'b0, rxEof = 1'b0, rxCrcErr = 1'b0, rxAlignErr = 1'b0;
  logic [7:0]  pageStart = 8'h40, pageStop = 8'h48, boundary = 8'h47;
  logic        cfgSaveErr = 1'b0, cfgAcceptRunt = 1'b0, cfgAcceptBcast = 1'b1, cfgMonitor = 1'b0;
  logic        memWe;
  logic [15:0] memAddr;
  logic [7:0]  memData, currPage, rxStatus, missedCount;
  logic        pktRcvd, rxErrPulse, ovwWarn;

  rx_ring_writer u_rx_ring_writer (.*);

  always #4 clk = ~clk;

  logic [7:0] benchMem [65536];
  logic [7:0] frameBuf [1024];
  int         expAddr  [1024];
  int wrCount = 0, pktCount = 0, errCount = 0, ovwCount = 0;
  int total = 0, bad = 0;
  bit done = 0;
  int mCurr = 'h40, mMissed = 0;
  bit autoRead = 1;

  always @(negedge clk) begin
    if (rstN) begin
      if (memWe) begin benchMem[memAddr] = memData; wrCount++; end
      if (pktRcvd) pktCount++;
      if (rxErrPulse) errCount++;
      if (ovwWarn) ovwCount++;
    end
  end

  task automatic checkEq(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int stepP(input int p);
    return (p + 1 == int'(pageStop)) ? int'(pageStart) : p + 1;
  endfunction
  function automatic int backP(input int p);
    return (p == int'(pageStart)) ? int'(pageStop) - 1 : p - 1;
  endfunction

  task automatic doReset(input int ps, input int pe);
    @(negedge clk);
    rstN = 1'b0; pageStart = 8'(ps); pageStop = 8'(pe); boundary = 8'(pe - 1);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    mCurr = ps; mMissed = 0;
  endtask

  task automatic driveFrame(input int len, input bit crc, input bit aln);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      while ($urandom % 4 == 0) begin
        rxValid = 1'b0; rxSof = 1'b0; rxEof = 1'b0;
        @(negedge clk);
      end
      rxValid = 1'b1; rxData = frameBuf[i];
      rxSof = (i == 0); rxEof = (i == len - 1);
      rxCrcErr = (i == len - 1) && crc; rxAlignErr = (i == len - 1) && aln;
    end
    @(negedge clk);
    rxValid = 1'b0; rxSof = 1'b0; rxEof = 1'b0; rxCrcErr = 1'b0; rxAlignErr = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic runFrame(input int len, input bit bc, input bit crc, input bit aln);
    int page, off, lastP, nextExp, nWr, mism, wr0, pk0, er0, ov0, expMiss;
    bit ovf, isB, keep, err, wrapped;
    logic [7:0] expSt;
    for (int i = 0; i < len; i++) frameBuf[i] = 8'($urandom);
    if (bc) for (int i = 0; i < 6 && i < len; i++) frameBuf[i] = 8'hFF;
    else if (len > 5) frameBuf[5] = frameBuf[5] & 8'hFE;
    // model
    ovf = 0; page = mCurr; off = 4; lastP = mCurr; nWr = 0; wrapped = 0;
    if (!cfgMonitor) begin
      for (int i = 0; i < len; i++) begin
        if (page == int'(boundary)) begin ovf = 1; break; end
        expAddr[i] = page * 256 + off; lastP = page; nWr++;
        if (off == 255) begin
          if (stepP(page) < page) wrapped = 1;
          page = stepP(page); off = 0;
        end else off++;
      end
    end
    nextExp = stepP(lastP);
    isB = bc && len >= 6;
    err = crc | aln;
    keep = !cfgMonitor && !ovf && (len >= 64 || cfgAcceptRunt) && (!err || cfgSaveErr) &&
           (!isB || cfgAcceptBcast);
    expSt = ovf ? 8'h10 : {1'b0, cfgMonitor, frameBuf[0][0], 2'b00, aln, crc, !err};
    if (cfgMonitor || ovf) mMissed = (mMissed == 255) ? 255 : mMissed + 1;
    wr0 = wrCount; pk0 = pktCount; er0 = errCount; ov0 = ovwCount;
    driveFrame(len, crc, aln);
    expMiss = mMissed;
    checkEq("R4/R6 currPage after frame", int'(currPage), keep ? nextExp : mCurr);
    checkEq("R11 status byte", int'(rxStatus), int'(expSt));
    checkEq("R9/R10/R12 missed count", int'(missedCount), expMiss);
    checkEq("R4/R6/R8 stored pulse count", pktCount - pk0, int'(keep));
    checkEq("R7/R10 error pulse count", errCount - er0, int'(ovf || err));
    checkEq("R10 overwrite pulse count", ovwCount - ov0, int'(ovf));
    checkEq("R2/R3/R9 write count", wrCount - wr0, nWr + (keep ? 4 : 0));
    if (keep) begin
      checkEq("R3 header status", int'(benchMem[mCurr*256 + 0]), int'(expSt));
      checkEq("R3/R5 header next page", int'(benchMem[mCurr*256 + 1]), nextExp);
      checkEq("R3 header length low", int'(benchMem[mCurr*256 + 2]), len & 255);
      checkEq("R3 header length high", int'(benchMem[mCurr*256 + 3]), len >> 8);
      mism = 0;
      for (int i = 0; i < len; i++) if (benchMem[expAddr[i]] != frameBuf[i]) mism++;
      checkEq(wrapped ? "R5 wrapped data bytes" : "R2 data bytes", mism, 0);
      mCurr = nextExp;
    end
    if (autoRead) begin
      @(negedge clk);
      boundary = 8'(backP(mCurr));
    end
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    doReset('h40, 'h48);
    @(negedge clk);
    checkEq("R1 reset currPage", int'(currPage), 'h40);
    checkEq("R1 reset missed", int'(missedCount), 0);
    checkEq("R1 reset status", int'(rxStatus), 0);
    checkEq("R1 reset outputs low", int'({memWe, pktRcvd, rxErrPulse, ovwWarn}), 0);
    boundary = 8'(backP(mCurr));
    // main function and runt threshold
    runFrame(64, 0, 0, 0);           // R2 R3 R4
    runFrame(63, 0, 0, 0);           // R6 runt dropped
    cfgAcceptRunt = 1'b1;
    runFrame(63, 0, 0, 0);           // R6 runt kept
    runFrame(1, 0, 0, 0);
    cfgAcceptRunt = 1'b0;
    // errored frames
    runFrame(100, 0, 1, 0);          // R7 dropped
    runFrame(100, 0, 0, 1);
    cfgSaveErr = 1'b1;
    runFrame(100, 0, 1, 1);          // R7 kept
    cfgSaveErr = 1'b0;
    // broadcast
    cfgAcceptBcast = 1'b0;
    runFrame(80, 1, 0, 0);           // R8 dropped
    runFrame(80, 0, 0, 0);
    cfgAcceptBcast = 1'b1;
    runFrame(80, 1, 0, 0);           // R8 kept
    // wrap across the limit page
    for (int k = 0; k < 5; k++) runFrame(500, 0, 0, 0);   // R5
    // monitor mode
    cfgMonitor = 1'b1;
    for (int k = 0; k < 3; k++) runFrame(70, 0, k == 1, 0);   // R9
    cfgMonitor = 1'b0;
    // overwrite blocked two pages ahead
    autoRead = 0;
    @(negedge clk);
    boundary = 8'(stepP(stepP(mCurr)));
    runFrame(700, 0, 0, 0);          // R10
    runFrame(64, 0, 0, 0);
    autoRead = 1;
    @(negedge clk);
    boundary = 8'(backP(mCurr));
    // random mix
    for (int k = 0; k < 60; k++) begin
      cfgSaveErr     = 1'($urandom);
      cfgAcceptRunt  = 1'($urandom);
      cfgAcceptBcast = 1'($urandom);
      cfgMonitor     = ($urandom % 10 == 0);
      runFrame(1 + int'($urandom % 700), ($urandom % 6 == 0), ($urandom % 8 == 0),
               ($urandom % 10 == 0));
    end
    // saturation of the missed counter
    cfgMonitor = 1'b0;
    doReset('h10, 'h20);
    boundary = 8'(backP(mCurr));
    cfgMonitor = 1'b1;
    for (int k = 0; k < 260; k++) runFrame(3, 0, 0, 0);   // R12
    checkEq("R12 missed saturated", int'(missedCount), 255);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule